// File: doc/BRIEF.md
# Converter Fault Protection Supervisor

This block is the digital fault supervisor for a synchronous step-down regulator. Each cycle it compares an unsigned feedback code against two limits derived from the present setpoint code. An overvoltage limit sits one eighth above the setpoint, and an undervoltage limit sits at seven tenths of it. From these comparisons it decides whether the power stage may switch, whether the low-side switch must be forced on, and which fault to report.

An overvoltage latches the low-side switch fully on, so the output capacitor discharges to ground. An undervoltage latches switching off, but only once a blanking window has run out after the converter leaves shutdown. Both latches stay set until the shutdown pin is asserted or the supply-good indication drops. An overvoltage defeat input masks only the overvoltage check. A test request masks every fault, clears the latches and forces skip operation. A thermal flag stops switching for as long as it is raised, and it is not latched.

Top module: `fault_supervisor`

## Requirements
- R1: An overvoltage is detected when fb_code_i > dac_code_i + floor(dac_code_i/8). Equality does not trip. The limit follows whatever setpoint code is applied.
- R2: Once overvoltage is latched, lowside_on_o=1, pwm_en_o=0 and fault_code_o=1. This holds even after the feedback returns to normal.
- R3: The fault latches are cleared only by asserting shutdown (shdn_n_i=0) or by dropping supply_ok_i to 0.
- R4: Undervoltage is ignored for BLANK_MS milliseconds of clock, counted from each exit from shutdown or supply recovery.
- R5: After blanking, fb_code_i < floor(dac_code_i*7/10) latches undervoltage. This gives pwm_en_o=0, lowside_on_o=0 and fault_code_o=2. Equality does not trip.
- R6: While shutdown is asserted or uvlo_i=1, lowside_on_o=1 and pwm_en_o=0. Shutdown is seen after a two-flop synchroniser.
- R7: ovp_defeat_i=1 suppresses overvoltage detection only. Undervoltage still trips.
- R8: test_mode_i=1 clears both latches on the next edge, blocks overvoltage, undervoltage and thermal faults, and sets skip_force_o=1.
- R9: thermal_i=1 (outside test mode) gives pwm_en_o=0 and fault_code_o=3 while it is high. It is not latched.
- R10: Overvoltage takes precedence. An overvoltage detected in the same cycle as an undervoltage, or while undervoltage is latched, replaces it with the overvoltage fault.
- R11: After reset with shutdown asserted, lowside_on_o=1, pwm_en_o=0, skip_force_o=0 and fault_code_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shdn_n_i | input | 1 | Asynchronous shutdown pin, 0 = shutdown |
| supply_ok_i | input | 1 | Supply above its reset level |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| fb_code_i | input | CODE_W | Sampled feedback code |
| dac_code_i | input | CODE_W | Setpoint code |
| ovp_defeat_i | input | 1 | Disable overvoltage protection |
| test_mode_i | input | 1 | No-fault test request |
| thermal_i | input | 1 | Over-temperature flag |
| lowside_on_o | output | 1 | Force low-side switch on |
| pwm_en_o | output | 1 | Allow switching |
| skip_force_o | output | 1 | Force skip (pulse-skipping) operation |
| fault_code_o | output | 2 | 0 none, 1 overvoltage, 2 undervoltage, 3 thermal |

## Verification
The checks assume that supply_ok_i, uvlo_i, the codes, the defeat and test inputs and the thermal flag are synchronous to clk. Only shdn_n_i may arrive asynchronously. The latch-retention property also assumes that shdn_n_i has stayed high long enough to pass the synchroniser. The stimulus changes every input on the falling edge and holds shdn_n_i steady for several cycles around each toggle, so these assumptions hold. Blanking is shortened through the clock-frequency parameter so that the window fits easily into the run.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_OVER    = 2'd1,
    FLT_UNDER   = 2'd2,
    FLT_THERMAL = 2'd3
  } fault_code_e;
endpackage

// File: rtl/fsup_shdn_sync.sv
module fsup_shdn_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n_i,
  output logic run_o,
  output logic exit_pulse_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= shdn_n_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign run_o        = sync_q;
  assign exit_pulse_o = sync_q & ~prev_q;
endmodule

// File: rtl/fsup_thresh.sv
module fsup_thresh #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] dac_code_i,
  input  logic [CODE_W-1:0] fb_code_i,
  output logic              ov_det_o,
  output logic              uv_det_o
);
  localparam int OVW = CODE_W + 1;
  localparam int UVW = CODE_W + 3;

  logic [OVW-1:0] ov_lim;
  logic [UVW-1:0] uv_prod;
  logic [UVW-1:0] uv_lim;

  always_comb begin
    ov_lim   = {1'b0, dac_code_i} + {4'b0, dac_code_i[CODE_W-1:3]};
    uv_prod  = {3'b0, dac_code_i} * UVW'(7);
    uv_lim   = uv_prod / UVW'(10);
    ov_det_o = {1'b0, fb_code_i} > ov_lim;
    uv_det_o = {3'b0, fb_code_i} < uv_lim;
  end
endmodule

// File: rtl/fsup_blank_timer.sv
module fsup_blank_timer #(
  parameter int BLANK_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic restart_i,
  output logic armed_o
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = hold_i | restart_i | (cnt_q != LAST);
    if (hold_i || restart_i) cnt_d = '0;
    else                     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed_o = (cnt_q == LAST);
endmodule

// File: rtl/fsup_fault_latch.sv
module fsup_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic ov_set_i,
  input  logic uv_set_i,
  output logic ov_q_o,
  output logic uv_q_o
);
  logic ov_q, uv_q, ov_d, uv_d;

  always_comb begin
    if (clear_i) begin
      ov_d = 1'b0;
      uv_d = 1'b0;
    end else begin
      ov_d = ov_q | ov_set_i;
      uv_d = ~ov_d & (uv_q | uv_set_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      uv_q <= uv_d;
    end
  end

  assign ov_q_o = ov_q;
  assign uv_q_o = uv_q;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int CLK_HZ   = 1_000_000,
  parameter int BLANK_MS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n_i,
  input  logic              supply_ok_i,
  input  logic              uvlo_i,
  input  logic [CODE_W-1:0] fb_code_i,
  input  logic [CODE_W-1:0] dac_code_i,
  input  logic              ovp_defeat_i,
  input  logic              test_mode_i,
  input  logic              thermal_i,
  output logic              lowside_on_o,
  output logic              pwm_en_o,
  output logic              skip_force_o,
  output logic [1:0]        fault_code_o
);
  localparam int BLANK_CYC = (CLK_HZ / 1000) * BLANK_MS;

  logic run, exit_pulse, ov_det, uv_det, armed;
  logic clear, ov_set, uv_set, ov_q, uv_q, therm_act;
  fault_code_e code;

  fsup_shdn_sync u_sync (
    .clk(clk), .rst_n(rst_n), .shdn_n_i(shdn_n_i),
    .run_o(run), .exit_pulse_o(exit_pulse)
  );

  fsup_thresh #(.CODE_W(CODE_W)) u_thr (
    .dac_code_i(dac_code_i), .fb_code_i(fb_code_i),
    .ov_det_o(ov_det), .uv_det_o(uv_det)
  );

  fsup_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n),
    .hold_i(~run | ~supply_ok_i), .restart_i(exit_pulse),
    .armed_o(armed)
  );

  always_comb begin
    clear     = ~run | ~supply_ok_i | test_mode_i;
    ov_set    = ov_det & ~ovp_defeat_i;
    uv_set    = uv_det & armed;
    therm_act = thermal_i & ~test_mode_i;
  end

  fsup_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clear_i(clear),
    .ov_set_i(ov_set), .uv_set_i(uv_set),
    .ov_q_o(ov_q), .uv_q_o(uv_q)
  );

  always_comb begin
    if (ov_q)           code = FLT_OVER;
    else if (uv_q)      code = FLT_UNDER;
    else if (therm_act) code = FLT_THERMAL;
    else                code = FLT_NONE;
    lowside_on_o = ~run | uvlo_i | ov_q;
    pwm_en_o     = run & supply_ok_i & ~uvlo_i & (code == FLT_NONE);
    skip_force_o = test_mode_i;
    fault_code_o = code;
  end
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk
  import fault_sup_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_n_i,
  input logic              supply_ok_i,
  input logic              uvlo_i,
  input logic              ovp_defeat_i,
  input logic              test_mode_i,
  input logic              lowside_on_o,
  input logic              pwm_en_o,
  input logic              skip_force_o,
  input logic [1:0]        fault_code_o
);
  // R2
  ov_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code_o == FLT_OVER) |-> (lowside_on_o && !pwm_en_o));

  // R3
  ov_retained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_code_o == FLT_OVER) && $past(supply_ok_i) && !$past(test_mode_i)
     && $past(shdn_n_i) && $past(shdn_n_i, 2) && $past(shdn_n_i, 3))
    |-> (fault_code_o == FLT_OVER));

  // R6
  uvlo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> (lowside_on_o && !pwm_en_o));

  // R7
  defeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovp_defeat_i) && $past(fault_code_o != FLT_OVER))
    |-> (fault_code_o != FLT_OVER));

  // R8
  test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && $past(test_mode_i)) |-> (fault_code_o == FLT_NONE && skip_force_o));

  // R9
  pwm_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en_o |-> (fault_code_o == FLT_NONE));
endmodule

bind fault_supervisor fault_supervisor_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .shdn_n_i(shdn_n_i), .supply_ok_i(supply_ok_i),
  .uvlo_i(uvlo_i), .ovp_defeat_i(ovp_defeat_i), .test_mode_i(test_mode_i),
  .lowside_on_o(lowside_on_o), .pwm_en_o(pwm_en_o),
  .skip_force_o(skip_force_o), .fault_code_o(fault_code_o)
);

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int HZ = 10_000;
  localparam int BMS = 20;
  localparam int BLANK = (HZ / 1000) * BMS;

  logic clk = 1'b0;
  logic rst_n, shdn_n, sup_ok, uvlo, defeat, test, therm;
  logic [W-1:0] fb, dac;
  logic ls_on, pwm_en, skip;
  logic [1:0] fcode;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor #(.CODE_W(W), .CLK_HZ(HZ), .BLANK_MS(BMS)) dut_i (
    .clk(clk), .rst_n(rst_n), .shdn_n_i(shdn_n), .supply_ok_i(sup_ok),
    .uvlo_i(uvlo), .fb_code_i(fb), .dac_code_i(dac), .ovp_defeat_i(defeat),
    .test_mode_i(test), .thermal_i(therm), .lowside_on_o(ls_on),
    .pwm_en_o(pwm_en), .skip_force_o(skip), .fault_code_o(fcode)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ov_lim(input int d); return d + d / 8; endfunction
  function automatic int uv_lim(input int d); return (d * 7) / 10; endfunction

  // leave shutdown and let blanking expire with a healthy feedback
  task automatic start_run();
    shdn_n = 1'b1;
    fb = W'(dac);
    step(BLANK + 10);
  endtask

  task automatic toggle_shdn();
    shdn_n = 1'b0;
    step(5);
  endtask

  task automatic t_reset();
    chk("R11 lowside", int'(ls_on), 1);
    chk("R11 pwm", int'(pwm_en), 0);
    chk("R11 skip", int'(skip), 0);
    chk("R11 fault", int'(fcode), 0);
  endtask

  task automatic t_blanking();
    shdn_n = 1'b1;
    fb = 8'd50;
    step(3);
    chk("R6 run after exit pwm", int'(pwm_en), 1);
    chk("R6 run after exit lowside", int'(ls_on), 0);
    step(BLANK - 20);
    chk("R4 blanked pwm", int'(pwm_en), 1);
    step(30);
    chk("R5 uv fault", int'(fcode), 2);
    chk("R5 uv pwm", int'(pwm_en), 0);
    chk("R5 uv lowside", int'(ls_on), 0);
    fb = W'(dac);
    step(5);
    chk("R3 uv retained", int'(fcode), 2);
    toggle_shdn();
    chk("R6 shutdown lowside", int'(ls_on), 1);
    chk("R3 cleared by shutdown", int'(fcode), 0);
  endtask

  task automatic t_uv_edge();
    start_run();
    fb = W'(uv_lim(int'(dac)));
    step(3);
    chk("R5 uv equal no trip", int'(fcode), 0);
    fb = W'(uv_lim(int'(dac)) - 1);
    step(1);
    chk("R5 uv below trips", int'(fcode), 2);
    toggle_shdn();
  endtask

  task automatic t_ov();
    start_run();
    fb = W'(ov_lim(int'(dac)));
    step(3);
    chk("R1 ov equal no trip", int'(fcode), 0);
    fb = W'(ov_lim(int'(dac)) + 1);
    step(1);
    chk("R1 ov trips", int'(fcode), 1);
    chk("R2 ov lowside", int'(ls_on), 1);
    chk("R2 ov pwm", int'(pwm_en), 0);
    fb = W'(dac);
    step(10);
    chk("R2 ov held", int'(fcode), 1);
    sup_ok = 1'b0;
    step(2);
    sup_ok = 1'b1;
    step(1);
    chk("R3 cleared by supply", int'(fcode), 0);
    dac = 8'd80;
    fb = W'(ov_lim(80));
    step(3);
    chk("R1 tracked equal", int'(fcode), 0);
    fb = W'(ov_lim(80) + 1);
    step(1);
    chk("R1 tracked trip", int'(fcode), 1);
    dac = 8'd160;
    toggle_shdn();
  endtask

  task automatic t_defeat();
    start_run();
    defeat = 1'b1;
    fb = 8'd250;
    step(3);
    chk("R7 ov defeated", int'(fcode), 0);
    chk("R7 pwm on", int'(pwm_en), 1);
    fb = 8'd10;
    step(1);
    chk("R7 uv still active", int'(fcode), 2);
    defeat = 1'b0;
    toggle_shdn();
  endtask

  task automatic t_uvlo_therm();
    start_run();
    uvlo = 1'b1;
    step(1);
    chk("R6 uvlo lowside", int'(ls_on), 1);
    chk("R6 uvlo pwm", int'(pwm_en), 0);
    uvlo = 1'b0;
    therm = 1'b1;
    step(1);
    chk("R9 thermal code", int'(fcode), 3);
    chk("R9 thermal pwm", int'(pwm_en), 0);
    therm = 1'b0;
    step(1);
    chk("R9 not latched", int'(pwm_en), 1);
  endtask

  task automatic t_priority();
    fb = 8'd10;
    step(1);
    chk("R10 uv first", int'(fcode), 2);
    fb = 8'd250;
    step(1);
    chk("R10 ov replaces uv", int'(fcode), 1);
    chk("R10 lowside", int'(ls_on), 1);
  endtask

  task automatic t_test_mode();
    test = 1'b1;
    fb = W'(dac);
    step(1);
    chk("R8 latch cleared", int'(fcode), 0);
    chk("R8 skip", int'(skip), 1);
    chk("R8 pwm", int'(pwm_en), 1);
    fb = 8'd250;
    step(2);
    chk("R8 ov blocked", int'(fcode), 0);
    fb = 8'd10;
    therm = 1'b1;
    step(2);
    chk("R8 uv and thermal blocked", int'(fcode), 0);
    chk("R8 pwm kept", int'(pwm_en), 1);
    therm = 1'b0;
    fb = W'(dac);
    step(1);
    test = 1'b0;
    step(1);
    chk("R8 skip released", int'(skip), 0);
  endtask

  initial begin
    rst_n = 1'b0; shdn_n = 1'b0; sup_ok = 1'b1; uvlo = 1'b0;
    defeat = 1'b0; test = 1'b0; therm = 1'b0;
    dac = 8'd160; fb = 8'd160;
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_blanking();
    t_uv_edge();
    t_ov();
    t_defeat();
    t_uvlo_therm();
    t_priority();
    t_test_mode();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule